// File: doc/BRIEF.md
# Multi-Domain Time-of-Day Counter

This block keeps a seconds and nanoseconds time-of-day for several independent clock domains (three by default). On every core clock edge an enabled domain adds a programmable 64-bit period: the top 5 bits are whole nanoseconds and the low 59 bits are a binary fraction of a nanosecond. The fraction is carried from cycle to cycle, so over a long run the rate matches the programmed period exactly. Whenever the nanoseconds reach one billion, the block moves the excess into the seconds.

Software reaches the counters through a small synchronous register bus. Time is set and read through a shared shadow set of registers: 16 upper seconds bits, 32 lower seconds bits and one nanoseconds word. Writing a command into the control register picks a domain and an action. The action can load the shadow time into the domain, capture the domain time into the shadow registers, or add a signed nanosecond offset. Each domain has its own enable bit. Each domain also has a guard bit that freezes the period the counter uses while software rewrites the two halves of that period. The live time of every domain is also driven on output ports.

Top module: `tod_engine`

## Requirements
- R1: After reset every domain reads 0 seconds and 0 ns. The control register (address 0) and the domain configuration register (address 4) read 0. Every period register reads the nominal 0x0FF8000000000000, with the low word at address 8+2d and the high word at address 9+2d.
- R2: An enabled domain adds its period on every clock edge. After k edges from a load, the nanoseconds equal the loaded value plus floor(k * period / 2^59). The fraction is reset to zero by a load.
- R3: When the nanoseconds reach 1,000,000,000 or more, 1,000,000,000 is subtracted and the seconds advance by one. A domain's nanoseconds never read 1,000,000,000 or above.
- R4: A domain whose enable bit (bit d of address 4) is clear, and which receives no action, keeps its time unchanged.
- R5: Control register layout: bits [2:0] hold the action (0 idle, 1 load, 2 save, 3 clock, 4 delta, 5 time-of-day), bits [5:4] hold the domain and bit 8 holds a sync flag. A load copies the shadow seconds (address 1 for the upper 16 bits, address 2 for the lower 32 bits) and the shadow nanoseconds (address 3) into the domain, on the edge after the control write.
- R6: A save copies the domain's seconds and nanoseconds into the shadow registers. The values captured are those the domain held just before the edge after the control write, so the snapshot is coherent while the domain counts.
- R7: A delta adds the shadow nanoseconds word, read as a signed 32-bit value, to the domain time, with a borrow from or carry into the seconds. A delta of magnitude 500,000,000 or more is ignored.
- R8: A non-idle action runs once and the action field then reads idle one cycle later. A control write that arrives while an action is still pending is ignored. The domain and sync fields keep their written values.
- R9: Actions 3, 5, 6 and 7, and any action aimed at domain select 3, leave every domain time and the shadow registers unchanged.
- R10: While mask bit d (bit 4+d of address 4) is set, domain d keeps counting with the period it was using before. Once the bit is cleared, the newly written period takes effect two edges later.
- R11: Domain d's time appears on tod_sec_o[d*48 +: 48] and tod_ns_o[d*30 +: 30].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |
| tod_sec_o | output | 144 | Seconds of every domain, packed by domain |
| tod_ns_o | output | 90 | Nanoseconds of every domain, packed by domain |

## Verification
A register write lands on the edge where wr_en_i is sampled, and the action it starts runs on the next edge. A load, save or delta is therefore visible at the falling edge that follows one full cycle after the write. The bench's write task returns at the falling edge just after the write edge, and the action helpers wait one further falling edge before they sample. The counting checks count the edges after the enable write, one increment per falling edge. The captured snapshot is compared with the output seen at the falling edge before the capture edge. The guard check counts the two-edge delay before an unmasked period is used.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [2:0] ACT_IDLE  = 3'd0;
  localparam logic [2:0] ACT_LOAD  = 3'd1;
  localparam logic [2:0] ACT_SAVE  = 3'd2;
  localparam logic [2:0] ACT_CLOCK = 3'd3;
  localparam logic [2:0] ACT_DELTA = 3'd4;
  localparam logic [2:0] ACT_TOD   = 3'd5;

  localparam int unsigned NS_PER_SEC  = 1000000000;
  localparam int unsigned A_CTRL      = 0;
  localparam int unsigned A_SH_SEC_HI = 1;
  localparam int unsigned A_SH_SEC_LO = 2;
  localparam int unsigned A_SH_NS     = 3;
  localparam int unsigned A_DOM_CFG   = 4;
  localparam int unsigned A_PER_BASE  = 8;
endpackage

// File: rtl/tod_access.sv
module tod_access
  import tod_pkg::*;
#(
  parameter int unsigned N_DOM = 3,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 4,
  parameter int unsigned SEC_W = 48,
  parameter int unsigned INC_W = 64,
  parameter int unsigned DOM_W = 2,
  parameter logic [INC_W-1:0] NOM_INC = 64'h0FF8000000000000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic [2:0]               act_o,
  output logic [DOM_W-1:0]         dom_o,
  output logic [N_DOM-1:0]         ena_o,
  output logic [N_DOM-1:0]         mask_o,
  output logic [N_DOM*INC_W-1:0]   stg_inc_o,
  output logic [SEC_W-1:0]         sh_sec_o,
  output logic [DW-1:0]            sh_ns_o,
  input  logic                     save_i,
  input  logic [SEC_W-1:0]         save_sec_i,
  input  logic [DW-1:0]            save_ns_i
);
  localparam int unsigned SEC_HI_W = SEC_W - DW;

  logic [2:0]          act_q;
  logic [DOM_W-1:0]    dom_q;
  logic                sync_q;
  logic [SEC_HI_W-1:0] sh_hi_q;
  logic [DW-1:0]       sh_lo_q, sh_ns_q;
  logic [N_DOM-1:0]    ena_q, mask_q;
  logic [INC_W-1:0]    stg_q [N_DOM];

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned r);
    return wr_en_i && (a == AW'(r));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= ACT_IDLE;
      dom_q   <= '0;
      sync_q  <= 1'b0;
      sh_hi_q <= '0;
      sh_lo_q <= '0;
      sh_ns_q <= '0;
      ena_q   <= '0;
      mask_q  <= '0;
      for (int d = 0; d < N_DOM; d++) stg_q[d] <= NOM_INC;
    end else begin
      // a pending action blocks any new command
      if (act_q != ACT_IDLE) act_q <= ACT_IDLE;
      else if (hit(addr_i, A_CTRL)) begin
        act_q  <= wdata_i[2:0];
        dom_q  <= wdata_i[4 +: DOM_W];
        sync_q <= wdata_i[8];
      end
      if (save_i) begin
        sh_hi_q <= save_sec_i[SEC_W-1:DW];
        sh_lo_q <= save_sec_i[DW-1:0];
        sh_ns_q <= save_ns_i;
      end else begin
        if (hit(addr_i, A_SH_SEC_HI)) sh_hi_q <= wdata_i[SEC_HI_W-1:0];
        if (hit(addr_i, A_SH_SEC_LO)) sh_lo_q <= wdata_i;
        if (hit(addr_i, A_SH_NS))     sh_ns_q <= wdata_i;
      end
      if (hit(addr_i, A_DOM_CFG)) begin
        ena_q  <= wdata_i[N_DOM-1:0];
        mask_q <= wdata_i[4 +: N_DOM];
      end
      for (int d = 0; d < N_DOM; d++) begin
        if (hit(addr_i, A_PER_BASE + 2*d))     stg_q[d][DW-1:0]     <= wdata_i;
        if (hit(addr_i, A_PER_BASE + 2*d + 1)) stg_q[d][INC_W-1:DW] <= wdata_i[INC_W-DW-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(A_CTRL)) begin
      rdata_o[2:0]        = act_q;
      rdata_o[4 +: DOM_W] = dom_q;
      rdata_o[8]          = sync_q;
    end
    if (addr_i == AW'(A_SH_SEC_HI)) rdata_o[SEC_HI_W-1:0] = sh_hi_q;
    if (addr_i == AW'(A_SH_SEC_LO)) rdata_o = sh_lo_q;
    if (addr_i == AW'(A_SH_NS))     rdata_o = sh_ns_q;
    if (addr_i == AW'(A_DOM_CFG)) begin
      rdata_o[N_DOM-1:0]  = ena_q;
      rdata_o[4 +: N_DOM] = mask_q;
    end
    for (int d = 0; d < N_DOM; d++) begin
      if (addr_i == AW'(A_PER_BASE + 2*d))     rdata_o = stg_q[d][DW-1:0];
      if (addr_i == AW'(A_PER_BASE + 2*d + 1)) rdata_o[INC_W-DW-1:0] = stg_q[d][INC_W-1:DW];
    end
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_stg
    assign stg_inc_o[d*INC_W +: INC_W] = stg_q[d];
  end

  assign act_o    = act_q;
  assign dom_o    = dom_q;
  assign ena_o    = ena_q;
  assign mask_o   = mask_q;
  assign sh_sec_o = {sh_hi_q, sh_lo_q};
  assign sh_ns_o  = sh_ns_q;
endmodule

// File: rtl/tod_domain.sv
module tod_domain
  import tod_pkg::*;
#(
  parameter int unsigned INC_W  = 64,
  parameter int unsigned FRAC_W = 59,
  parameter int unsigned NS_W   = 30,
  parameter int unsigned SEC_W  = 48,
  parameter int unsigned DW     = 32,
  parameter logic [INC_W-1:0] NOM_INC = 64'h0FF8000000000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ena_i,
  input  logic              upd_i,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              load_i,
  input  logic              delta_i,
  input  logic [SEC_W-1:0]  ld_sec_i,
  input  logic [NS_W-1:0]   ld_ns_i,
  input  logic [DW-1:0]     dl_ns_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o,
  output logic [INC_W-1:0]  inc_o
);
  localparam int unsigned IP_W = INC_W - FRAC_W;
  localparam int unsigned DLW  = NS_W + 3;
  localparam logic [NS_W:0]         NSPS   = (NS_W+1)'(NS_PER_SEC);
  localparam logic signed [DLW-1:0] NSPS_S = DLW'(NS_PER_SEC);

  logic [INC_W-1:0]  inc_q;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [NS_W-1:0]   ns_q, ns_d;
  logic [SEC_W-1:0]  sec_q, sec_d;

  logic [FRAC_W:0]         fsum;
  logic [NS_W:0]           ns_cnt;
  logic signed [DLW-1:0]   ns_dl;

  always_comb begin
    fsum   = {1'b0, frac_q} + {1'b0, inc_q[FRAC_W-1:0]};
    ns_cnt = {1'b0, ns_q} + (NS_W+1)'(inc_q[INC_W-1 -: IP_W]) + (NS_W+1)'(fsum[FRAC_W]);
    ns_dl  = $signed({3'b000, ns_q}) + $signed({{(DLW-DW){dl_ns_i[DW-1]}}, dl_ns_i});
    frac_d = frac_q;
    ns_d   = ns_q;
    sec_d  = sec_q;
    if (load_i) begin
      frac_d = '0;
      ns_d   = ld_ns_i;
      sec_d  = ld_sec_i;
    end else if (delta_i) begin
      if (ns_dl < 0) begin
        ns_d  = NS_W'(ns_dl + NSPS_S);
        sec_d = sec_q - 1'b1;
      end else if (ns_dl >= NSPS_S) begin
        ns_d  = NS_W'(ns_dl - NSPS_S);
        sec_d = sec_q + 1'b1;
      end else begin
        ns_d  = NS_W'(ns_dl);
      end
    end else if (ena_i) begin
      frac_d = fsum[FRAC_W-1:0];
      if (ns_cnt >= NSPS) begin
        ns_d  = NS_W'(ns_cnt - NSPS);
        sec_d = sec_q + 1'b1;
      end else begin
        ns_d  = NS_W'(ns_cnt);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q  <= NOM_INC;
      frac_q <= '0;
      ns_q   <= '0;
      sec_q  <= '0;
    end else begin
      if (upd_i) inc_q <= inc_i;
      frac_q <= frac_d;
      ns_q   <= ns_d;
      sec_q  <= sec_d;
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;
  assign inc_o = inc_q;
endmodule

// File: rtl/tod_engine.sv
module tod_engine
  import tod_pkg::*;
#(
  parameter int unsigned N_DOM  = 3,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 4,
  parameter int unsigned SEC_W  = 48,
  parameter int unsigned NS_W   = 30,
  parameter int unsigned INC_W  = 64,
  parameter int unsigned FRAC_W = 59,
  parameter logic [INC_W-1:0] NOM_INC = 64'h0FF8000000000000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic [N_DOM*SEC_W-1:0]  tod_sec_o,
  output logic [N_DOM*NS_W-1:0]   tod_ns_o
);
  localparam int unsigned DOM_W = 2;
  localparam logic signed [DW-1:0] DMAX = DW'(NS_PER_SEC / 2);

  logic [2:0]             act_w;
  logic [DOM_W-1:0]       dom_w;
  logic [N_DOM-1:0]       ena_w, mask_w;
  logic [N_DOM*INC_W-1:0] stg_w, inc_w;
  logic [SEC_W-1:0]       sh_sec_w, save_sec;
  logic [DW-1:0]          sh_ns_w, save_ns;
  logic                   dom_ok, delta_ok, save_hit;

  assign dom_ok   = int'(dom_w) < N_DOM;
  assign delta_ok = ($signed(sh_ns_w) > -DMAX) && ($signed(sh_ns_w) < DMAX);
  assign save_hit = (act_w == ACT_SAVE) && dom_ok;

  always_comb begin
    save_sec = '0;
    save_ns  = '0;
    for (int d = 0; d < N_DOM; d++) begin
      if (int'(dom_w) == d) begin
        save_sec = tod_sec_o[d*SEC_W +: SEC_W];
        save_ns  = DW'(tod_ns_o[d*NS_W +: NS_W]);
      end
    end
  end

  tod_access #(
    .N_DOM(N_DOM), .DW(DW), .AW(AW), .SEC_W(SEC_W), .INC_W(INC_W),
    .DOM_W(DOM_W), .NOM_INC(NOM_INC)
  ) u_access (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .act_o(act_w), .dom_o(dom_w),
    .ena_o(ena_w), .mask_o(mask_w), .stg_inc_o(stg_w), .sh_sec_o(sh_sec_w),
    .sh_ns_o(sh_ns_w), .save_i(save_hit), .save_sec_i(save_sec), .save_ns_i(save_ns)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic sel;
    assign sel = dom_ok && (int'(dom_w) == d);
    tod_domain #(
      .INC_W(INC_W), .FRAC_W(FRAC_W), .NS_W(NS_W), .SEC_W(SEC_W), .DW(DW),
      .NOM_INC(NOM_INC)
    ) u_dom (
      .clk_i(clk_i), .rst_ni(rst_ni), .ena_i(ena_w[d]), .upd_i(~mask_w[d]),
      .inc_i(stg_w[d*INC_W +: INC_W]),
      .load_i(sel && (act_w == ACT_LOAD)),
      .delta_i(sel && (act_w == ACT_DELTA) && delta_ok),
      .ld_sec_i(sh_sec_w), .ld_ns_i(sh_ns_w[NS_W-1:0]), .dl_ns_i(sh_ns_w),
      .sec_o(tod_sec_o[d*SEC_W +: SEC_W]), .ns_o(tod_ns_o[d*NS_W +: NS_W]),
      .inc_o(inc_w[d*INC_W +: INC_W])
    );
  end
endmodule

// File: rtl/tod_engine_chk.sv
module tod_engine_chk #(
  parameter int unsigned N_DOM = 3,
  parameter int unsigned DW    = 32,
  parameter int unsigned SEC_W = 48,
  parameter int unsigned NS_W  = 30,
  parameter int unsigned INC_W = 64,
  parameter int unsigned DOM_W = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [2:0]              act_i,
  input logic [DOM_W-1:0]        dom_i,
  input logic [N_DOM-1:0]        ena_i,
  input logic [N_DOM-1:0]        mask_i,
  input logic [N_DOM*SEC_W-1:0]  sec_i,
  input logic [N_DOM*NS_W-1:0]   ns_i,
  input logic [N_DOM*INC_W-1:0]  inc_i,
  input logic [DW-1:0]           sh_ns_i
);
  AST_ACT_RETURNS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i != 3'd0) |=> (act_i == 3'd0)); // R8

  AST_SAVE_SNAPSHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == 3'd2 && int'(dom_i) < N_DOM) |=>
      (sh_ns_i == DW'($past(ns_i[int'(dom_i)*NS_W +: NS_W])))); // R6

  for (genvar d = 0; d < N_DOM; d++) begin : g_d
    AST_NS_BELOW_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ns_i[d*NS_W +: NS_W] < NS_W'(1000000000)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ena_i[d] && !(act_i != 3'd0 && int'(dom_i) == d)) |=>
        ($stable(ns_i[d*NS_W +: NS_W]) && $stable(sec_i[d*SEC_W +: SEC_W]))); // R4

    AST_MASK_HOLDS_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_i[d] |=> $stable(inc_i[d*INC_W +: INC_W])); // R10

    AST_LOAD_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i == 3'd1 && int'(dom_i) == d) |=>
        (ns_i[d*NS_W +: NS_W] == $past(sh_ns_i[NS_W-1:0]))); // R5
  end
endmodule

bind tod_engine tod_engine_chk #(
  .N_DOM(N_DOM), .DW(DW), .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W), .DOM_W(DOM_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act_w), .dom_i(dom_w), .ena_i(ena_w),
  .mask_i(mask_w), .sec_i(tod_sec_o), .ns_i(tod_ns_o), .inc_i(inc_w), .sh_ns_i(sh_ns_w)
);

// File: tb/tb_tod_engine.sv
module tb_tod_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NSPS = 1000000000;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [143:0] tod_sec;
  logic [89:0]  tod_ns;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tod_sec_o(tod_sec), .tod_ns_o(tod_ns)
  );

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint ns_of(input int d);
    return longint'(tod_ns[d*30 +: 30]);
  endfunction
  function automatic longint sec_of(input int d);
    return longint'(tod_sec[d*48 +: 48]);
  endfunction

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input int a, input logic [31:0] v);
    wr_en = 1'b1; addr = 4'(a); wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = 4'(a);
    #1 v = rdata;
  endtask

  task automatic cmd(input int act, input int d);
    wr(0, 32'(act) | (32'(d) << 4));
    @(negedge clk);
  endtask

  task automatic load(input int d, input longint s, input longint n);
    wr(1, 32'(s >> 32));
    wr(2, 32'(s));
    wr(3, 32'(n));
    cmd(1, d);
  endtask

  task automatic delta(input int d, input int v);
    wr(3, 32'(v));
    cmd(4, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    longint s0, n0, e, es;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, r); check("R1 ctrl", r, 0);
    rd(4, r); check("R1 dom_cfg", r, 0);
    for (int d = 0; d < 3; d++) begin
      rd(8 + 2*d, r); check("R1 period lo", r, 0);
      rd(9 + 2*d, r); check("R1 period hi", r, 32'h0FF80000);
      check("R1 ns", ns_of(d), 0);
      check("R1 sec", sec_of(d), 0);
    end

    // R2 fractional periods: dom0 0.5 ns, dom1 2.5 ns
    wr(8, 0); wr(9, 32'h04000000);
    wr(10, 0); wr(11, 32'h14000000);
    load(0, 1, 1000);
    load(1, 1, 1000);
    check("R5 load ns", ns_of(0), 1000);
    check("R5 load sec", sec_of(1), 1);
    wr(4, 3);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check("R2 half ns", ns_of(0), 1000 + k/2);
      check("R2 2.5 ns", ns_of(1), 1000 + (5*k)/2);
    end

    // R6 save while counting (dom1)
    wr(0, 32'(2 | (1 << 4)));
    s0 = sec_of(1); n0 = ns_of(1);
    @(negedge clk);
    rd(3, r); check("R6 save ns", r, n0);
    rd(2, r); check("R6 save sec lo", r, s0);
    wr(4, 0);

    // R4 disabled domain holds
    s0 = ns_of(0); n0 = ns_of(1);
    repeat (5) @(negedge clk);
    check("R4 hold dom0", ns_of(0), s0);
    check("R4 hold dom1", ns_of(1), n0);

    // R3 rollover sweep over every integer period on dom2
    for (int ip = 1; ip < 32; ip++) begin
      wr(12, 0); wr(13, 32'(ip) << 27);
      load(2, 7, 999999980);
      wr(4, 4);
      repeat (3) @(negedge clk);
      wr(4, 0);
      e = 999999980 + 4*ip; es = 7;
      if (e >= NSPS) begin e -= NSPS; es++; end
      check("R3 ns after wrap", ns_of(2), e);
      check("R3 sec after wrap", sec_of(2), es);
    end

    // R7 delta on dom0
    load(0, 10, 200);
    delta(0, -300);
    check("R7 neg ns", ns_of(0), 999999900);
    check("R7 neg sec", sec_of(0), 9);
    delta(0, 100);
    check("R7 pos ns", ns_of(0), 0);
    check("R7 pos sec", sec_of(0), 10);
    delta(0, 500000000);
    check("R7 too big ignored", ns_of(0), 0);
    delta(0, -500000000);
    check("R7 too small ignored", sec_of(0), 10);
    delta(0, 499999999);
    check("R7 max delta", ns_of(0), 499999999);

    // R8 back-to-back commands: second is dropped
    load(2, 0, 55);
    wr(1, 0); wr(2, 3); wr(3, 333);
    wr(0, 32'(1 | (1 << 4) | (1 << 8)));
    wr(0, 32'(1 | (2 << 4)));
    @(negedge clk);
    check("R8 first load", ns_of(1), 333);
    check("R8 second ignored", ns_of(2), 55);
    rd(0, r);
    check("R8 action idle", r[2:0], 0);
    check("R8 domain kept", r[5:4], 1);
    check("R8 sync kept", r[8], 1);

    // R9 reserved actions and invalid domain
    cmd(3, 0);
    check("R9 clock action", ns_of(0), 499999999);
    cmd(5, 0);
    check("R9 tod action", ns_of(0), 499999999);
    cmd(1, 3);
    check("R9 dom3 d0", ns_of(0), 499999999);
    check("R9 dom3 d2", ns_of(2), 55);
    cmd(2, 3);
    rd(3, r); check("R9 shadow kept", r, 333);

    // R10 guarded period update on dom2
    wr(12, 0); wr(13, 32'h20000000);
    load(2, 0, 0);
    wr(4, 32'h40);
    wr(13, 32'h40000000);
    wr(4, 32'h44);
    repeat (4) @(negedge clk);
    check("R10 old period kept", ns_of(2), 16);
    wr(4, 0);
    check("R10 old period at stop", ns_of(2), 20);
    repeat (2) @(negedge clk);
    load(2, 0, 0);
    wr(4, 4);
    repeat (3) @(negedge clk);
    check("R10 new period", ns_of(2), 24);
    check("R11 sec slice", sec_of(2), 0);
    wr(4, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule